// File: doc/BRIEF.md
# Boundary-Mapped Stack and Port Access Steering Unit

This unit sits between a processor's address generation and its 64K RAM bus. For every load or store it adds a signed displacement to a base pointer. When the sum stays inside the 16-bit address space, the access goes to RAM. When the sum falls below zero or rises above the top address, the access turns into an I/O port access instead, and the amount of overshoot gives the port number. The processor therefore needs no separate I/O instructions.

Stack operations are steered by the stack pointer value. A push with the stack pointer at zero writes into a small internal bank of service registers, and a pop with the stack pointer at the top address reads from that bank. A push with the stack pointer at one selects the service page. A push or pop of the accumulator pair in either boundary mode only steps to the next register. Pages whose index holds a hex letter digit are reserved for supervisor code. A user-mode transfer to or from one of these pages is refused with a fault pulse. Every result appears on the registered outputs one clock after the request is sampled.

Top module: `bmsp_steer`

## Requirements
- R1: A load (req_kind 00) or store (req_kind 01) whose sum base_ptr + sign-extended offset lies in 0..65535 gives, one cycle later, a single ram_req pulse with ram_addr equal to that sum, ram_we high only for a store, and ram_wdata equal to wdata for a store.
- R2: A load or store whose sum is negative becomes a port access one cycle later: port_req pulses, port_we is high only for a store, and port_num is the low byte of the two's-complement sum (base 0x0000 with offset -1 gives port 255). For a store, port_wdata equals wdata.
- R3: A load or store whose sum exceeds 65535 becomes a port access, and port_num is the low byte of (sum - 65535). For example, base 0xFFFF with offset +1 gives port 1.
- R4: A push (req_kind 10) with base_ptr 0x0000 and req_ax low writes wdata into service register (page slot, index) and advances the index modulo 4. The page slot is the low 4 bits of the page. No RAM or port strobe is raised.
- R5: A pop (req_kind 11) with base_ptr 0xFFFF and req_ax low raises svc_rvalid one cycle later with svc_rdata equal to the current service register, then advances the index modulo 4.
- R6: A push at base 0x0000 or a pop at base 0xFFFF with req_ax high transfers nothing and raises no strobe, but still advances the index.
- R7: A push with base_ptr 0x0001 loads wdata[7:0] as the page and clears the index to 0. It raises no strobe.
- R8: A page with either hex digit in A..F is a system page. On a system page, a non-accumulator boundary push or pop with user_mode high raises fault for exactly one cycle. It writes nothing and leaves the index unchanged. With user_mode low the same access is performed.
- R9: A push or pop at any other base_ptr goes to RAM at address base_ptr, ignores offset, and is a write for push and a read for pop.
- R10: After reset all strobes are low, the page and index are 0, and all service registers read 0.
- R11: A cycle with req_valid low raises no strobe and no fault in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 load, 01 store, 10 push, 11 pop |
| req_ax | input | 1 | Stack operand is the accumulator pair |
| user_mode | input | 1 | High for application code, low for supervisor |
| base_ptr | input | 16 | Pointer register value (stack pointer for push/pop) |
| offset | input | 16 | Signed displacement for load/store |
| wdata | input | 16 | Store or push data |
| ram_req | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 16 | RAM write data |
| port_req | output | 1 | Port access strobe |
| port_we | output | 1 | Port write enable |
| port_num | output | 8 | Port number |
| port_wdata | output | 16 | Port write data |
| svc_rvalid | output | 1 | Service register read data valid |
| svc_rdata | output | 16 | Service register read data |
| fault | output | 1 | Refused system-page access |

## Verification
The hardest state to reach from the ports is a refused user access on a system page that sits on an index other than zero. To get there, the stimulus must first select a page with a push at stack pointer one. It must then step the index with accumulator pushes, and only then issue the user-mode transfer. A following supervisor pop shows that the refused push neither wrote the register nor moved the index. A directed sequence builds exactly this chain. A long mixed phase afterwards draws base pointers mostly from the three boundary values and the range edges, so that these chains also form in other orders.

// File: rtl/bmsp_pkg.sv
package bmsp_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_PUSH  = 2'b10,
        ACC_POP   = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/bmsp_ea_calc.sv
// Effective address sum with range escape detection and port numbering.
module bmsp_ea_calc #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic              escape,
    output logic [ADDR_W-1:0] addr,
    output logic [PORT_W-1:0] port
);
    localparam int SUM_W = ADDR_W + 2;

    logic signed [SUM_W-1:0] sum;
    logic                    below;
    logic                    above;

    assign sum    = $signed({2'b00, base}) + $signed({{2{offset[ADDR_W-1]}}, offset});
    assign below  = sum[SUM_W-1];
    assign above  = !below && sum[ADDR_W];
    assign escape = below || above;
    assign addr   = sum[ADDR_W-1:0];
    // Above the top address the overshoot counts from one; below zero the
    // two's-complement low byte is used directly.
    assign port   = below ? sum[PORT_W-1:0] : sum[PORT_W-1:0] + PORT_W'(1);
endmodule

// File: rtl/bmsp_page_guard.sv
// Flags a page index carrying any hex letter digit as a system page.
module bmsp_page_guard #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    output logic              is_sys
);
    localparam int NIBS = PAGE_W / 4;

    logic [NIBS-1:0] nib_sys;

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign nib_sys[g] = page[4*g +: 4] > 4'd9;
    end

    assign is_sys = |nib_sys;
endmodule

// File: rtl/bmsp_svc_bank.sv
// Service register storage: one shared address for read and write.
module bmsp_svc_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/bmsp_steer.sv
// Steers loads, stores, pushes and pops to RAM, ports or service registers.
module bmsp_steer
    import bmsp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int PORT_W     = 8,
    parameter int PAGE_W     = 8,
    parameter int SVC_REGS   = 4,
    parameter int PAGE_SLOTS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_ax,
    input  logic              user_mode,
    input  logic [ADDR_W-1:0] base_ptr,
    input  logic [ADDR_W-1:0] offset,
    input  logic [DATA_W-1:0] wdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              port_req,
    output logic              port_we,
    output logic [PORT_W-1:0] port_num,
    output logic [DATA_W-1:0] port_wdata,
    output logic              svc_rvalid,
    output logic [DATA_W-1:0] svc_rdata,
    output logic              fault
);
    localparam int IDX_W  = $clog2(SVC_REGS);
    localparam int SLOT_W = $clog2(PAGE_SLOTS);
    localparam int DEPTH  = SVC_REGS * PAGE_SLOTS;
    localparam logic [ADDR_W-1:0] SP_WR_EDGE   = '0;
    localparam logic [ADDR_W-1:0] SP_PAGE_EDGE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SP_RD_EDGE   = '1;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  idx;
        logic              ram_req;
        logic              ram_we;
        logic [ADDR_W-1:0] ram_addr;
        logic [DATA_W-1:0] ram_wdata;
        logic              port_req;
        logic              port_we;
        logic [PORT_W-1:0] port_num;
        logic [DATA_W-1:0] port_wdata;
        logic              svc_rvalid;
        logic [DATA_W-1:0] svc_rdata;
        logic              fault;
    } steer_state_t;

    steer_state_t st_d, st_q;

    logic              ea_escape;
    logic [ADDR_W-1:0] ea_addr;
    logic [PORT_W-1:0] ea_port;
    logic              page_sys;
    logic              bank_we;
    logic [DATA_W-1:0] bank_rdata;
    logic [SLOT_W+IDX_W-1:0] bank_addr;
    logic              deny;
    acc_kind_e         kind;

    bmsp_ea_calc #(
        .ADDR_W (ADDR_W),
        .PORT_W (PORT_W)
    ) i_ea (
        .base   (base_ptr),
        .offset (offset),
        .escape (ea_escape),
        .addr   (ea_addr),
        .port   (ea_port)
    );

    bmsp_page_guard #(
        .PAGE_W (PAGE_W)
    ) i_guard (
        .page   (st_q.page),
        .is_sys (page_sys)
    );

    assign bank_addr = {st_q.page[SLOT_W-1:0], st_q.idx};

    bmsp_svc_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we),
        .addr   (bank_addr),
        .wdata  (wdata),
        .rdata  (bank_rdata)
    );

    assign kind = acc_kind_e'(req_kind);
    assign deny = user_mode && page_sys;

    always_comb begin
        st_d            = st_q;
        st_d.ram_req    = 1'b0;
        st_d.ram_we     = 1'b0;
        st_d.port_req   = 1'b0;
        st_d.port_we    = 1'b0;
        st_d.svc_rvalid = 1'b0;
        st_d.fault      = 1'b0;
        bank_we         = 1'b0;

        if (req_valid) begin
            unique case (kind)
                ACC_LOAD, ACC_STORE: begin
                    if (ea_escape) begin
                        st_d.port_req   = 1'b1;
                        st_d.port_we    = (kind == ACC_STORE);
                        st_d.port_num   = ea_port;
                        st_d.port_wdata = wdata;
                    end else begin
                        st_d.ram_req    = 1'b1;
                        st_d.ram_we     = (kind == ACC_STORE);
                        st_d.ram_addr   = ea_addr;
                        st_d.ram_wdata  = wdata;
                    end
                end
                ACC_PUSH: begin
                    if (base_ptr == SP_WR_EDGE) begin
                        if (req_ax) begin
                            st_d.idx = st_q.idx + IDX_W'(1);
                        end else if (deny) begin
                            st_d.fault = 1'b1;
                        end else begin
                            bank_we  = 1'b1;
                            st_d.idx = st_q.idx + IDX_W'(1);
                        end
                    end else if (base_ptr == SP_PAGE_EDGE) begin
                        st_d.page = wdata[PAGE_W-1:0];
                        st_d.idx  = '0;
                    end else begin
                        st_d.ram_req   = 1'b1;
                        st_d.ram_we    = 1'b1;
                        st_d.ram_addr  = base_ptr;
                        st_d.ram_wdata = wdata;
                    end
                end
                ACC_POP: begin
                    if (base_ptr == SP_RD_EDGE) begin
                        if (req_ax) begin
                            st_d.idx = st_q.idx + IDX_W'(1);
                        end else if (deny) begin
                            st_d.fault = 1'b1;
                        end else begin
                            st_d.svc_rvalid = 1'b1;
                            st_d.svc_rdata  = bank_rdata;
                            st_d.idx        = st_q.idx + IDX_W'(1);
                        end
                    end else begin
                        st_d.ram_req  = 1'b1;
                        st_d.ram_we   = 1'b0;
                        st_d.ram_addr = base_ptr;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_req    = st_q.ram_req;
    assign ram_we     = st_q.ram_we;
    assign ram_addr   = st_q.ram_addr;
    assign ram_wdata  = st_q.ram_wdata;
    assign port_req   = st_q.port_req;
    assign port_we    = st_q.port_we;
    assign port_num   = st_q.port_num;
    assign port_wdata = st_q.port_wdata;
    assign svc_rvalid = st_q.svc_rvalid;
    assign svc_rdata  = st_q.svc_rdata;
    assign fault      = st_q.fault;
endmodule

// File: rtl/bmsp_steer_checker.sv
module bmsp_steer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        req_ax,
    input logic        user_mode,
    input logic [15:0] base_ptr,
    input logic [15:0] offset,
    input logic        ram_req,
    input logic        port_req,
    input logic [7:0]  port_num,
    input logic        svc_rvalid,
    input logic        fault
);
    // R1: at most one destination per cycle
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_req, port_req, svc_rvalid, fault}));

    // R11: idle request cycle leaves all strobes low next cycle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(ram_req || port_req || svc_rvalid || fault));

    // R2: the lowest escape below zero lands on port 255
    assert_below_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind[1] && base_ptr == 16'h0000 && offset == 16'hFFFF)
        |=> (port_req && port_num == 8'hFF));

    // R3: the smallest escape above the top lands on port 1
    assert_above_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind[1] && base_ptr == 16'hFFFF && offset == 16'h0001)
        |=> (port_req && port_num == 8'h01));

    // R4: stack operations never reach the port space
    assert_stack_no_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[1]) |=> !port_req);

    // R5: service read data only follows a non-accumulator pop at the top edge
    assert_svc_read_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_rvalid |-> $past(req_valid && req_kind == 2'b11 && base_ptr == 16'hFFFF && !req_ax));

    // R6: accumulator transfers in boundary modes raise nothing
    assert_ax_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ax && ((req_kind == 2'b10 && base_ptr == 16'h0000) ||
                                 (req_kind == 2'b11 && base_ptr == 16'hFFFF)))
        |=> !(ram_req || port_req || svc_rvalid || fault));

    // R8: supervisor requests never fault, and a fault lasts one cycle
    assert_sup_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !user_mode) |=> !fault);
    assert_fault_from_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(req_valid && user_mode && req_kind[1]));
endmodule

bind bmsp_steer bmsp_steer_checker i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_ax     (req_ax),
    .user_mode  (user_mode),
    .base_ptr   (base_ptr),
    .offset     (offset),
    .ram_req    (ram_req),
    .port_req   (port_req),
    .port_num   (port_num),
    .svc_rvalid (svc_rvalid),
    .fault      (fault)
);

// File: tb/test_bmsp_steer.sv
`timescale 1ns/1ps
module test_bmsp_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_ax = 1'b0;
    logic        user_mode = 1'b0;
    logic [15:0] base_ptr = '0;
    logic [15:0] offset = '0;
    logic [15:0] wdata = '0;
    logic        ram_req, ram_we, port_req, port_we, svc_rvalid, fault;
    logic [15:0] ram_addr, ram_wdata, port_wdata, svc_rdata;
    logic [7:0]  port_num;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_page = 0;
    int m_idx  = 0;
    int m_mem [64];

    always #4 clk = ~clk;

    bmsp_steer i_bmsp_steer (
        .clk, .rst_n, .req_valid, .req_kind, .req_ax, .user_mode,
        .base_ptr, .offset, .wdata,
        .ram_req, .ram_we, .ram_addr, .ram_wdata,
        .port_req, .port_we, .port_num, .port_wdata,
        .svc_rvalid, .svc_rdata, .fault
    );

    function automatic bit is_sys(int p);
        return (((p >> 4) & 15) > 9) || ((p & 15) > 9);
    endfunction

    task automatic step(input string tag, input bit v, input int k, input bit ax,
                        input bit usr, input int base, input int off, input int wd);
        bit e_ram = 0, e_we = 0, e_port = 0, e_pwe = 0, e_rv = 0, e_fault = 0;
        int e_addr = 0, e_pnum = 0, e_rdata = 0, s, slot;
        bit bad;
        @(negedge clk);
        req_valid = v; req_kind = k[1:0]; req_ax = ax; user_mode = usr;
        base_ptr = base[15:0]; offset = off[15:0]; wdata = wd[15:0];
        slot = (m_page & 15) * 4 + m_idx;
        if (v) begin
            case (k)
                0, 1: begin
                    s = base + ((off >= 32768) ? off - 65536 : off);
                    if (s < 0 || s > 65535) begin
                        e_port = 1; e_pwe = (k == 1);
                        e_pnum = (s < 0) ? ((s + 65536) & 255) : ((s - 65535) & 255);
                    end else begin
                        e_ram = 1; e_we = (k == 1); e_addr = s;
                    end
                end
                2: begin
                    if (base == 0) begin
                        if (ax) m_idx = (m_idx + 1) % 4;
                        else if (usr && is_sys(m_page)) e_fault = 1;
                        else begin m_mem[slot] = wd; m_idx = (m_idx + 1) % 4; end
                    end else if (base == 1) begin
                        m_page = wd & 255; m_idx = 0;
                    end else begin
                        e_ram = 1; e_we = 1; e_addr = base;
                    end
                end
                default: begin
                    if (base == 65535) begin
                        if (ax) m_idx = (m_idx + 1) % 4;
                        else if (usr && is_sys(m_page)) e_fault = 1;
                        else begin e_rv = 1; e_rdata = m_mem[slot]; m_idx = (m_idx + 1) % 4; end
                    end else begin
                        e_ram = 1; e_we = 0; e_addr = base;
                    end
                end
            endcase
        end
        @(posedge clk);
        #1;
        bad = (ram_req !== e_ram) || (port_req !== e_port) ||
              (svc_rvalid !== e_rv) || (fault !== e_fault);
        if (e_ram)  bad |= (ram_we !== e_we) || (ram_addr !== e_addr[15:0]) ||
                           (e_we && ram_wdata !== wd[15:0]);
        if (e_port) bad |= (port_we !== e_pwe) || (port_num !== e_pnum[7:0]) ||
                           (e_pwe && port_wdata !== wd[15:0]);
        if (e_rv)   bad |= (svc_rdata !== e_rdata[15:0]);
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: actual ram=%0b/%0b/%h port=%0b/%0b/%h rv=%0b/%h flt=%0b expected ram=%0b/%0b/%h port=%0b/%0b/%h rv=%0b/%h flt=%0b",
                     tag, ram_req, ram_we, ram_addr, port_req, port_we, port_num,
                     svc_rvalid, svc_rdata, fault, e_ram, e_we, e_addr[15:0],
                     e_port, e_pwe, e_pnum[7:0], e_rv, e_rdata[15:0], e_fault);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (ram_req || port_req || svc_rvalid || fault) begin
            n_bad++;
            $display("FAIL R10 strobes in reset: actual %b expected 0000",
                     {ram_req, port_req, svc_rvalid, fault});
        end
        @(negedge clk); rst_n = 1'b1;
        step("R10 idle after reset", 0, 0, 0, 0, 0, 0, 0);
        step("R10 first service read is zero", 1, 3, 0, 0, 65535, 0, 0);
        step("R11 idle with stack edge inputs", 0, 2, 0, 0, 0, 0, 16'h5555);
        // R1 in range
        step("R1 load in range", 1, 0, 0, 1, 16'h1000, 16'hFFF0, 0);
        step("R1 store top address", 1, 1, 0, 1, 16'h8000, 16'h7FFF, 16'hBEEF);
        step("R1 store zero address", 1, 1, 0, 0, 16'h0005, 16'hFFFB, 16'h1234);
        // R2 below zero
        step("R2 load base 0 off -1", 1, 0, 0, 0, 0, 16'hFFFF, 0);
        step("R2 store to port F0", 1, 1, 0, 1, 16'h0010, 16'hFFE0, 16'hCAFE);
        // R3 above top
        step("R3 store base FFFF off +1", 1, 1, 0, 0, 16'hFFFF, 1, 16'h00A5);
        step("R3 load to port 81", 1, 0, 0, 1, 16'hFF00, 16'h0180, 0);
        // R4 writes with index wrap, R5 reads
        for (int i = 0; i < 5; i++)
            step("R4 service push", 1, 2, 0, 1, 0, 16'h0033, 16'hA100 + i);
        for (int i = 0; i < 4; i++)
            step("R5 service pop", 1, 3, 0, 1, 65535, 0, 0);
        // R6 accumulator skips
        step("R6 ax push skip", 1, 2, 1, 1, 0, 0, 16'h7777);
        step("R6 ax pop skip", 1, 3, 1, 1, 65535, 0, 0);
        step("R5 pop after skips", 1, 3, 0, 1, 65535, 0, 0);
        // R7 page select
        step("R7 page select 05", 1, 2, 0, 1, 1, 0, 16'h0005);
        step("R7 write on new page", 1, 2, 0, 1, 0, 0, 16'h5A5A);
        step("R7 page reselect clears index", 1, 2, 0, 1, 1, 0, 16'h0005);
        step("R7 read back index 0", 1, 3, 0, 1, 65535, 0, 0);
        // R8 system page
        step("R8 select page 3A", 1, 2, 0, 1, 1, 0, 16'h003A);
        step("R8 ax step on system page", 1, 2, 1, 1, 0, 0, 0);
        step("R8 user push refused", 1, 2, 0, 1, 0, 0, 16'hDEAD);
        step("R8 user pop refused", 1, 3, 0, 1, 65535, 0, 0);
        step("R8 supervisor pop index 1 untouched", 1, 3, 0, 0, 65535, 0, 0);
        step("R8 supervisor push allowed", 1, 2, 0, 0, 0, 0, 16'h0BAD);
        step("R8 select page C0", 1, 2, 0, 0, 1, 0, 16'h00C0);
        step("R8 user pop on C0 refused", 1, 3, 0, 1, 65535, 0, 0);
        step("R8 select page 99", 1, 2, 0, 0, 1, 0, 16'h0099);
        step("R8 user push on 99 allowed", 1, 2, 0, 1, 0, 0, 16'h9999);
        // R9 ordinary stack
        step("R9 push to RAM", 1, 2, 0, 1, 16'h2000, 16'h0040, 16'h4321);
        step("R9 pop from RAM", 1, 3, 0, 1, 16'hFFFE, 16'h0010, 0);
        step("R9 push at 0002", 1, 2, 0, 1, 2, 0, 16'h0101);
        // mixed phase
        for (int n = 0; n < 3000; n++) begin
            int sel, b, o, k;
            sel = $urandom_range(0, 9);
            case (sel)
                0: b = 0;
                1: b = 1;
                2: b = 65535;
                3: b = $urandom_range(0, 15);
                4: b = $urandom_range(65520, 65535);
                default: b = $urandom_range(0, 65535);
            endcase
            k = $urandom_range(0, 3);
            if (k == 2 && b == 1 && $urandom_range(0, 1) == 1) o = $urandom_range(0, 255);
            else o = $urandom_range(0, 65535);
            step("mixed R1 R2 R3 R4 R5 R6 R7 R8 R9 R11",
                 $urandom_range(0, 7) != 0, k, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 1), b, o,
                 (k == 2 && b == 1) ? $urandom_range(0, 255) : $urandom_range(0, 65535));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule